// File: doc/BRIEF.md
# Host Shared-RAM Slave Port

This block is the host-facing slave port of a chip that shares a word-wide RAM with an internal protocol engine. A host processor reaches either the shared RAM or a small file of control registers through one 16-bit port. Its signals are an active-low select, an active-low strobe, a direction line and a 16-bit address. The port answers on an active-low `ready_n` line, and it drives read data with an output-enable so that a pad ring can tri-state the bus.

Two static straps adapt the port to its host. `pol_strap` sets which level of `rw` means write. `ack_mode` chooses the handshake. In acknowledge mode (`ack_mode`=1), `ready_n` is an acknowledge that goes low once the access is complete. In zero-wait mode (`ack_mode`=0), the host may end its strobe at any time. The port then completes the transfer in the background, and `ready_n` becomes a busy flag that rests low. The internal engine's claim on the RAM is modelled by `mem_busy`, which stalls RAM accesses.

The control FSM has five states. `S_IDLE` has no transfer in progress. `S_A_WAIT` is an acknowledge-mode access waiting for the RAM. `S_A_DONE` is an acknowledge-mode access that has finished, with `ready_n` held low until the strobe ends. `S_Z_HOLD` is a zero-wait strobe in progress, with the request being captured. `S_Z_PEND` is a zero-wait transfer that is still outstanding after the strobe was released.

The transitions are as follows:
- `S_IDLE`→`S_A_WAIT` on a strobe in acknowledge mode.
- `S_IDLE`→`S_Z_HOLD` on a strobe in zero-wait mode.
- `S_A_WAIT`→`S_A_DONE` when access is granted.
- `S_A_DONE`→`S_IDLE` on strobe or select release.
- `S_Z_HOLD`→`S_Z_PEND` on release.
- `S_Z_PEND`→`S_IDLE` when access is granted.

Access is granted when `mem_busy` is low or the target is a register.

Top module: `hostram_slave`

## Requirements
- R1: After reset, `data_oe` is 0 and `ready_n` is 1 in acknowledge mode and 0 in zero-wait mode. The read-data register holds 0, so the first zero-wait read returns 0x0000.
- R2: With `pol_strap`=0 a low `rw` is a write and a high `rw` is a read. With `pol_strap`=1 a high `rw` is a write and a low `rw` is a read.
- R3: In acknowledge mode, `ready_n` falls only after the write data has been stored. A later read of the same location returns that data.
- R4: In acknowledge mode, a read drives `ready_n` low together with `data_oe`=1 and valid `rdata`. `ready_n` stays low while the strobe is held and is high again in the cycle after release.
- R5: In zero-wait mode, `ready_n` is low while no transfer is outstanding, including during the strobe. It goes high in the cycle after the strobe release is sampled and stays high until the transfer has completed.
- R6: In zero-wait mode, a write uses the address and data present in the last clock cycle in which select and strobe were both low. Changes to the address, data or `rw` after release have no effect.
- R7: A zero-wait read drives onto the bus the word fetched by the previous read in either mode. Its own fetch, taken from the location it addressed, becomes the word returned by the next read.
- R8: While `mem_busy` is 1, no RAM access takes place and `ready_n` is withheld (high in acknowledge mode, kept high in zero-wait mode). Register accesses complete regardless of `mem_busy`.
- R9: `data_oe` is 0 whenever `sel_n` or `strb_n` is high, and it is 1 only for reads.
- R10: `addr[15]`=0 selects the RAM, indexed by `addr[RAM_AW-1:0]`. `addr[15]`=1 selects a register, indexed by `addr[REG_AW-1:0]`. Bits between the index and bit 15 are ignored. RAM and registers are separate storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ack_mode | input | 1 | Strap: 1 acknowledge mode, 0 zero-wait mode |
| pol_strap | input | 1 | Strap: write sense of `rw` |
| sel_n | input | 1 | Port select, active low |
| strb_n | input | 1 | Access strobe, active low |
| rw | input | 1 | Direction line, sense set by `pol_strap` |
| addr | input | 16 | Word address; bit 15 picks registers |
| wdata | input | 16 | Write data from host |
| mem_busy | input | 1 | Protocol engine holds the RAM |
| rdata | output | 16 | Read data toward the host |
| data_oe | output | 1 | Read-data output enable |
| ready_n | output | 1 | Acknowledge / busy flag, active low |

## Verification
The hardest situation to reach from the ports is a zero-wait transfer that is still pending while `mem_busy` stretches it. During that window the host has already let go and has put new, conflicting address and data values on the bus. The bench reaches it by releasing the strobe and, on the same falling clock edge, asserting `mem_busy` for a random number of cycles while inverting `addr`, `wdata` and `rw`. It then checks that `ready_n` stays high throughout and that a later acknowledged read returns the captured word. The random phase mixes both modes and both polarities with register targets under a held `mem_busy`. A reference model tracks the prefetched read word across mode changes to compute each zero-wait read result.

// File: rtl/hs_pkg.sv
package hs_pkg;

    localparam int HS_ADDR_W = 16;
    localparam int HS_DATA_W = 16;

    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_A_WAIT = 3'd1,
        S_A_DONE = 3'd2,
        S_Z_HOLD = 3'd3,
        S_Z_PEND = 3'd4
    } hs_state_t;

    typedef struct packed {
        logic                 wr;
        logic                 is_reg;
        logic [HS_ADDR_W-1:0] addr;
        logic [HS_DATA_W-1:0] wdata;
    } hs_access_t;

endpackage

// File: rtl/hs_decode.sv
module hs_decode
    import hs_pkg::*;
#(
    parameter int REGION_BIT = HS_ADDR_W - 1
) (
    input  logic                 rw,
    input  logic                 pol_strap,
    input  logic [HS_ADDR_W-1:0] addr,
    input  logic [HS_DATA_W-1:0] wdata,
    output hs_access_t           acc
);

    // Direction sense follows the polarity strap (R2); region bit splits RAM/registers (R10)
    always_comb begin
        acc.wr     = pol_strap ? rw : ~rw;
        acc.is_reg = addr[REGION_BIT];
        acc.addr   = addr;
        acc.wdata  = wdata;
    end

endmodule

// File: rtl/hs_store.sv
module hs_store
    import hs_pkg::*;
#(
    parameter int RAM_AW = 11,
    parameter int REG_AW = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  hs_access_t           acc,
    input  logic                 do_access,
    input  logic                 mem_busy,
    output logic [HS_DATA_W-1:0] rd_q
);

    localparam int RAM_DEPTH = 1 << RAM_AW;
    localparam int REG_N     = 1 << REG_AW;

    logic                 ram_we;
    logic                 reg_we;
    logic                 rd_load;
    logic [RAM_AW-1:0]    ram_idx;
    logic [REG_AW-1:0]    reg_idx;
    logic [HS_DATA_W-1:0] ram_mem [RAM_DEPTH];
    logic [HS_DATA_W-1:0] reg_q   [REG_N];
    logic                 unused_bits;

    assign ram_idx     = acc.addr[RAM_AW-1:0];
    assign reg_idx     = acc.addr[REG_AW-1:0];
    assign ram_we      = do_access &  acc.wr & ~acc.is_reg;
    assign reg_we      = do_access &  acc.wr &  acc.is_reg;
    assign rd_load     = do_access & ~acc.wr;
    assign unused_bits = ^{acc.addr[HS_ADDR_W-1:RAM_AW], mem_busy};

    always_ff @(posedge clk) begin
        if (ram_we) begin
            ram_mem[ram_idx] <= acc.wdata;
        end
    end

    generate
        for (genvar g = 0; g < REG_N; g++) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    reg_q[g] <= '0;
                end else if (reg_we && reg_idx == REG_AW'(g)) begin
                    reg_q[g] <= acc.wdata;
                end
            end
        end
    endgenerate

    // Single read-data register: acknowledged reads and zero-wait prefetch (R7)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (rd_load) begin
            rd_q <= acc.is_reg ? reg_q[reg_idx] : ram_mem[ram_idx];
        end
    end

    // R8: the RAM is never written while the engine holds it
    p_ram_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> !mem_busy);

endmodule

// File: rtl/hs_ctrl.sv
module hs_ctrl
    import hs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ack_mode,
    input  logic       sel_n,
    input  logic       strb_n,
    input  logic       mem_busy,
    input  hs_access_t acc_in,
    output hs_access_t acc_q,
    output logic       do_access,
    output logic       ready_n,
    output logic       data_oe
);

    hs_state_t state;
    hs_state_t state_nx;
    logic      start;
    logic      grant;
    logic      cap;

    assign start = ~sel_n & ~strb_n;
    assign grant = ~mem_busy | acc_q.is_reg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (cap) begin
            acc_q <= acc_in;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:   if (start) state_nx = ack_mode ? S_A_WAIT : S_Z_HOLD;
            S_A_WAIT: if (grant) state_nx = S_A_DONE;
            S_A_DONE: if (!start) state_nx = S_IDLE;
            S_Z_HOLD: if (!start) state_nx = S_Z_PEND;
            S_Z_PEND: if (grant) state_nx = S_IDLE;
            default:  state_nx = S_IDLE;
        endcase
    end

    always_comb begin
        ready_n   = 1'b1;
        data_oe   = 1'b0;
        do_access = 1'b0;
        cap       = 1'b0;
        unique case (state)
            S_IDLE: begin
                ready_n = ack_mode;
                cap     = start;
            end
            S_A_WAIT: begin
                do_access = grant;
            end
            S_A_DONE: begin
                ready_n = 1'b0;
                data_oe = start & ~acc_q.wr;
            end
            S_Z_HOLD: begin
                ready_n = 1'b0;
                cap     = start;
                data_oe = start & ~acc_q.wr;
            end
            S_Z_PEND: begin
                do_access = grant;
            end
            default: ;
        endcase
    end

    // R3: in acknowledge mode ready only falls after the access was carried out
    p_ack_after_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_mode && $fell(ready_n)) |-> $past(do_access));

    // R5: a sampled strobe release in zero-wait mode raises the busy flag
    p_zw_flag_on_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_mode && state == S_Z_HOLD && !start) |=> ready_n);

    // R5: once the background transfer is done the flag rests low again
    p_zw_rest_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_mode && do_access) |=> !ready_n);

    // R8: a RAM target is not accessed while the engine holds the RAM
    p_busy_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_busy && !acc_q.is_reg) |-> !do_access);

endmodule

// File: rtl/hostram_slave.sv
module hostram_slave
    import hs_pkg::*;
#(
    parameter int RAM_AW = 11,
    parameter int REG_AW = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ack_mode,
    input  logic        pol_strap,
    input  logic        sel_n,
    input  logic        strb_n,
    input  logic        rw,
    input  logic [15:0] addr,
    input  logic [15:0] wdata,
    input  logic        mem_busy,
    output logic [15:0] rdata,
    output logic        data_oe,
    output logic        ready_n
);

    hs_access_t acc_in;
    hs_access_t acc_q;
    logic       do_access;

    hs_decode #(
        .REGION_BIT(HS_ADDR_W - 1)
    ) u_decode (
        .rw        (rw),
        .pol_strap (pol_strap),
        .addr      (addr),
        .wdata     (wdata),
        .acc       (acc_in)
    );

    hs_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ack_mode  (ack_mode),
        .sel_n     (sel_n),
        .strb_n    (strb_n),
        .mem_busy  (mem_busy),
        .acc_in    (acc_in),
        .acc_q     (acc_q),
        .do_access (do_access),
        .ready_n   (ready_n),
        .data_oe   (data_oe)
    );

    hs_store #(
        .RAM_AW(RAM_AW),
        .REG_AW(REG_AW)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc       (acc_q),
        .do_access (do_access),
        .mem_busy  (mem_busy),
        .rd_q      (rdata)
    );

    // R9: the bus is only driven while the port reports ready
    p_oe_with_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> !ready_n);

endmodule

// File: tb/hostram_slave_bench.sv
module hostram_slave_bench;

    localparam int RAM_AW    = 11;
    localparam int REG_AW    = 3;
    localparam int RAM_DEPTH = 1 << RAM_AW;
    localparam int REG_N     = 1 << REG_AW;
    localparam int POOL_N    = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ack_mode = 1'b1;
    logic        pol_strap = 1'b0;
    logic        sel_n = 1'b1;
    logic        strb_n = 1'b1;
    logic        rw = 1'b1;
    logic [15:0] addr = '0;
    logic [15:0] wdata = '0;
    logic        mem_busy = 1'b0;
    logic [15:0] rdata;
    logic        data_oe;
    logic        ready_n;

    int checks = 0;
    int errors = 0;

    logic [15:0] ram_m [RAM_DEPTH];
    logic [15:0] reg_m [REG_N];
    logic [15:0] pf;

    always #5 clk = ~clk;

    hostram_slave #(.RAM_AW(RAM_AW), .REG_AW(REG_AW)) u_hostram_slave (
        .clk(clk), .rst_n(rst_n), .ack_mode(ack_mode), .pol_strap(pol_strap),
        .sel_n(sel_n), .strb_n(strb_n), .rw(rw), .addr(addr), .wdata(wdata),
        .mem_busy(mem_busy), .rdata(rdata), .data_oe(data_oe), .ready_n(ready_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int pool_idx(input int i);
        return (i * 613 + 7) % RAM_DEPTH;
    endfunction

    function automatic logic [15:0] mk_addr(input bit isreg, input int idx);
        logic [15:0] a;
        a = 16'($urandom);
        a[15] = isreg;
        if (isreg) a[REG_AW-1:0] = REG_AW'(idx);
        else       a[RAM_AW-1:0] = RAM_AW'(idx);
        return a;
    endfunction

    function automatic logic rw_for(input bit wr);
        return pol_strap ? wr : !wr;
    endfunction

    function automatic logic [15:0] model_rd(input bit isreg, input int idx);
        return isreg ? reg_m[idx] : ram_m[idx];
    endfunction

    task automatic model_wr(input bit isreg, input int idx, input logic [15:0] d);
        if (isreg) reg_m[idx] = d;
        else       ram_m[idx] = d;
    endtask

    // Acknowledge-mode access (R3, R4, R8, R9)
    task automatic ack_op(input bit wr, input bit isreg, input int idx,
                          input logic [15:0] d, input int busy, input int hold);
        int n;
        logic [15:0] expv;
        @(negedge clk);
        ack_mode = 1'b1;
        rw = rw_for(wr); addr = mk_addr(isreg, idx); wdata = d;
        sel_n = 1'b0; strb_n = 1'b0; mem_busy = (busy > 0);
        if (!isreg) begin
            repeat (busy) begin
                @(negedge clk);
                chk("R8 ack stall", ready_n, 1);
            end
            mem_busy = 1'b0;
        end
        n = 0;
        do begin @(negedge clk); n++; end while (ready_n && n < 20);
        chk("R3/R4/R8 ready latency", n, (isreg || busy == 0) ? 2 : 1);
        if (wr) begin
            model_wr(isreg, idx, d);
            chk("R9 no drive on write", data_oe, 0);
        end else begin
            expv = model_rd(isreg, idx);
            chk("R4 read data", rdata, expv);
            chk("R4 read enable", data_oe, 1);
            pf = expv;
        end
        repeat (hold) begin
            @(negedge clk);
            chk("R4 ready held", ready_n, 0);
        end
        sel_n = 1'b1; strb_n = 1'b1; mem_busy = 1'b0;
        #1 chk("R9 release tristate", data_oe, 0);
        @(negedge clk);
        chk("R4 ready off after release", ready_n, 1);
    endtask

    // Zero-wait access (R5, R6, R7, R8, R9)
    task automatic zw_op(input bit wr, input bit isreg, input int idx,
                         input logic [15:0] d, input int busy, input int hold);
        @(negedge clk);
        ack_mode = 1'b0;
        rw = rw_for(wr); addr = mk_addr(isreg, idx); wdata = d;
        sel_n = 1'b0; strb_n = 1'b0;
        repeat (hold + 1) begin
            @(negedge clk);
            chk("R5 low during strobe", ready_n, 0);
            if (!wr) begin
                chk("R7 prefetched word", rdata, pf);
                chk("R9 read enable", data_oe, 1);
            end else begin
                chk("R9 no drive on write", data_oe, 0);
            end
        end
        sel_n = 1'b1; strb_n = 1'b1;
        addr = ~addr; wdata = ~wdata; rw = ~rw;
        mem_busy = (busy > 0);
        #1 chk("R9 release tristate", data_oe, 0);
        @(negedge clk);
        chk("R5 flag high after release", ready_n, 1);
        if (!isreg && busy > 0) begin
            repeat (busy - 1) begin
                @(negedge clk);
                chk("R8 zw stall", ready_n, 1);
            end
            mem_busy = 1'b0;
        end
        @(negedge clk);
        chk("R5/R8 flag low after transfer", ready_n, 0);
        mem_busy = 1'b0;
        if (wr) model_wr(isreg, idx, d);
        else    pf = model_rd(isreg, idx);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1553));
        pf = '0;
        for (int i = 0; i < REG_N; i++) reg_m[i] = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 ready ack idle", ready_n, 1);
        chk("R1 oe idle", data_oe, 0);
        rst_n = 1'b1;
        @(negedge clk);
        ack_mode = 1'b0;
        #1 chk("R1 ready zw rest", ready_n, 0);
        zw_op(1'b0, 1'b1, 2, 16'h0, 0, 0);   // first read returns reset word (R1/R7)

        // R2: both polarities
        pol_strap = 1'b0;
        ack_op(1'b1, 1'b0, pool_idx(0), 16'hA5C3, 0, 0);
        ack_op(1'b0, 1'b0, pool_idx(0), 16'h0, 0, 0);
        pol_strap = 1'b1;
        ack_op(1'b1, 1'b0, pool_idx(0), 16'h3C5A, 0, 1);
        ack_op(1'b0, 1'b0, pool_idx(0), 16'h0, 0, 0);
        chk("R2 polarity write seen", ram_m[pool_idx(0)], 16'h3C5A);

        // Fill RAM pool and registers (R3, R10)
        for (int i = 0; i < POOL_N; i++) ack_op(1'b1, 1'b0, pool_idx(i), 16'($urandom), 0, 0);
        for (int i = 0; i < REG_N; i++) ack_op(1'b1, 1'b1, i, 16'($urandom), 0, 0);

        // R10: register write does not alias RAM with the same low bits
        ack_op(1'b1, 1'b0, 3, 16'h1111, 0, 0);
        ack_op(1'b1, 1'b1, 3, 16'h2222, 0, 0);
        ack_op(1'b0, 1'b0, 3, 16'h0, 0, 0);
        chk("R10 separate storage", pf, 16'h1111);

        // R6/R7: zero-wait write then reads with prefetch
        zw_op(1'b1, 1'b0, pool_idx(5), 16'hBEEF, 0, 2);
        zw_op(1'b0, 1'b0, pool_idx(5), 16'h0, 0, 0);
        zw_op(1'b0, 1'b1, 3, 16'h0, 0, 1);
        ack_op(1'b0, 1'b0, pool_idx(5), 16'h0, 0, 0);
        chk("R6 captured write", pf, 16'hBEEF);

        // R8: busy stalls RAM, not registers
        ack_op(1'b1, 1'b0, pool_idx(6), 16'h7E57, 4, 0);
        ack_op(1'b0, 1'b1, 1, 16'h0, 5, 0);
        zw_op(1'b1, 1'b0, pool_idx(7), 16'h4D2A, 6, 0);
        zw_op(1'b1, 1'b1, 6, 16'h9911, 3, 0);
        ack_op(1'b0, 1'b0, pool_idx(7), 16'h0, 0, 0);

        // Random mix
        for (int k = 0; k < 300; k++) begin
            bit wr, isreg;
            int idx;
            wr        = 1'($urandom);
            isreg     = ($urandom % 4) == 0;
            idx       = isreg ? int'($urandom % REG_N) : pool_idx(int'($urandom % POOL_N));
            pol_strap = 1'($urandom);
            if (1'($urandom))
                ack_op(wr, isreg, idx, 16'($urandom), int'($urandom % 4), int'($urandom % 3));
            else
                zw_op(wr, isreg, idx, 16'($urandom), int'($urandom % 4), int'($urandom % 3));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule